// File: doc/BRIEF.md
# Saturating Trim Register with Nonvolatile Store

This block holds a 7-bit trim code that drives a DAC. Single-cycle up and down strobes from an upstream pulse qualifier move the code by one step. The code stops at both ends of its range and never wraps. At power-up, the block fetches the saved code from a nonvolatile memory port. It fetches it again each time the enable input falls. This lets a fresh setting be compared against the saved one without cycling power.

A program request saves the present code to the memory. The write is a one-cycle write strobe followed by a fixed busy window that models the slow cell write. Strobes and requests that arrive while the block is busy, or while enable is low, have no effect. After power-up, and again after every completed write, the next accepted strobe is discarded. This guards against a false edge on the control line. The control and status pins are plain level or pulse signals. There is no valid/ready stream at this boundary, so no back-pressure applies. The memory is expected to accept a write and answer a read without stalling.

Top module: `trim_register`

## Requirements
- R1: While enabled, idle and not suppressed, a strobe on `step_up` alone raises `dac_code` by one, and a strobe on `step_dn` alone lowers it by one. The new value is visible after the clock edge that samples the strobe.
- R2: The code saturates. An up strobe at 127 leaves 127, and a down strobe at 0 leaves 0.
- R3: After reset, `nv_rd_req` is high for the first cycle. `nv_rd_data` is captured on the next edge. From then on, `code_valid` is 1, `dac_code` equals the stored value and `busy` is 0.
- R4: A falling edge on `en` starts a new read, and `dac_code` returns to the stored value.
- R5: While `en` is low, strobes and program requests change neither `dac_code` nor the memory.
- R6: A program request produces exactly one `nv_wr_req` cycle carrying the present code on `nv_wr_data`. `busy` is high for 1 + WR_BUSY_CYCLES cycles, starting on the edge that accepts the request.
- R7: While `busy` is high, strobes and program requests are ignored.
- R8: After the power-up load, and after each completed write, the first accepted strobe (up or down) is discarded. The strobes after it count normally.
- R9: Each program request made when idle performs its own full write, even if the code has not changed.
- R10: Before the first load completes, `dac_code` is 0 and `code_valid` is 0.
- R11: Up and down together in one cycle are ignored and do not use up the suppression. A strobe in the same cycle as a program request is ignored, and the write carries the code from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| en | input | 1 | Adjust/program enable; a falling edge triggers a reload |
| step_up | input | 1 | One-cycle increment strobe |
| step_dn | input | 1 | One-cycle decrement strobe |
| prog_req | input | 1 | One-cycle request to store the code |
| nv_rd_req | output | 1 | Memory read strobe |
| nv_rd_data | input | 7 | Memory read data, sampled one cycle after `nv_rd_req` |
| nv_wr_req | output | 1 | Memory write strobe |
| nv_wr_data | output | 7 | Memory write data |
| dac_code | output | 7 | Trim code to the DAC |
| code_valid | output | 1 | High once the first load has completed |
| busy | output | 1 | Load or write sequence in progress |

## Verification
Three kinds of corrupted state show up at the ports:
- A corrupted code register appears on `dac_code` on the edge after the strobe that exposes it.
- A stuck suppression flag shows as either a missing step or an extra step on the first strobe after a load or a write.
- A wrong sequencer state shows as a busy window of the wrong length, a missing or doubled write strobe, or a reload that never arrives. Each of these can be seen within WR_BUSY_CYCLES + 2 cycles of the triggering input.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [2:0] {
    SQ_RD_REQ,
    SQ_RD_CAP,
    SQ_IDLE,
    SQ_WR_REQ,
    SQ_WR_WAIT
  } seq_state_t;
endpackage

// File: rtl/trim_sat_counter.sv
module trim_sat_counter #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_stb,
  input  logic [CODE_W-1:0] load_val,
  input  logic              inc,
  input  logic              dec,
  output logic [CODE_W-1:0] code,
  output logic              valid
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code  <= '0;
      valid <= 1'b0;
    end else if (load_stb) begin
      code  <= load_val;
      valid <= 1'b1;
    end else if (inc && !dec && code != CODE_MAX) begin
      code <= code + 1'b1;
    end else if (dec && !inc && code != CODE_MIN) begin
      code <= code - 1'b1;
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_MAX && inc && !load_stb) |=> code == CODE_MAX);
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_MIN && dec && !load_stb) |=> code == CODE_MIN);
  assert_zero_before_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> code == '0);
  assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> code == $past(load_val));
endmodule

// File: rtl/trim_step_gate.sv
module trim_step_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  input  logic up,
  input  logic dn,
  input  logic write_done,
  output logic inc,
  output logic dec
);
  logic skip_armed;
  logic single;

  assign single = allow && (up ^ dn);
  assign inc    = single && up && !skip_armed;
  assign dec    = single && dn && !skip_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          skip_armed <= 1'b1;
    else if (write_done) skip_armed <= 1'b1;
    else if (single)     skip_armed <= 1'b0;
  end

  assert_blocked_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |-> !(inc || dec));
  assert_not_both_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec));
  assert_skip_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    write_done |=> !(inc || dec));
endmodule

// File: rtl/trim_nv_sequencer.sv
module trim_nv_sequencer
  import trim_pkg::*;
#(
  parameter int CODE_W         = 7,
  parameter int WR_BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              prog_req,
  input  logic [CODE_W-1:0] cur_code,
  output logic              nv_rd_req,
  output logic              nv_wr_req,
  output logic [CODE_W-1:0] nv_wr_data,
  output logic              load_stb,
  output logic              write_done,
  output logic              busy
);
  localparam int BW = $clog2(WR_BUSY_CYCLES + 1);
  localparam logic [BW-1:0] WAIT_LAST = BW'(WR_BUSY_CYCLES - 1);

  seq_state_t        state;
  logic [BW-1:0]     wait_cnt;
  logic              en_q;
  logic              reload_pend;
  logic              en_fall;
  logic [CODE_W-1:0] wr_hold;

  assign en_fall    = en_q && !en;
  assign nv_rd_req  = state == SQ_RD_REQ;
  assign load_stb   = state == SQ_RD_CAP;
  assign nv_wr_req  = state == SQ_WR_REQ;
  assign nv_wr_data = wr_hold;
  assign write_done = state == SQ_WR_WAIT && wait_cnt == '0;
  assign busy       = state != SQ_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SQ_RD_REQ;
      wait_cnt    <= '0;
      en_q        <= 1'b0;
      reload_pend <= 1'b0;
      wr_hold     <= '0;
    end else begin
      en_q <= en;
      if (en_fall) reload_pend <= 1'b1;
      unique case (state)
        SQ_RD_REQ: state <= SQ_RD_CAP;
        SQ_RD_CAP: state <= SQ_IDLE;
        SQ_IDLE: begin
          if (reload_pend || en_fall) begin
            reload_pend <= 1'b0;
            state       <= SQ_RD_REQ;
          end else if (prog_req && en) begin
            wr_hold <= cur_code;
            state   <= SQ_WR_REQ;
          end
        end
        SQ_WR_REQ: begin
          wait_cnt <= WAIT_LAST;
          state    <= SQ_WR_WAIT;
        end
        SQ_WR_WAIT: begin
          if (wait_cnt == '0) state <= SQ_IDLE;
          else                wait_cnt <= wait_cnt - 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assert_read_then_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nv_rd_req |=> load_stb);
  assert_single_write_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr_req |=> !nv_wr_req);
  assert_write_data_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !nv_rd_req && !load_stb && $past(busy)) |-> $stable(nv_wr_data));
  assert_busy_ends_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    write_done |=> !busy);
endmodule

// File: rtl/trim_register.sv
module trim_register #(
  parameter int CODE_W         = 7,
  parameter int WR_BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              step_up,
  input  logic              step_dn,
  input  logic              prog_req,
  output logic              nv_rd_req,
  input  logic [CODE_W-1:0] nv_rd_data,
  output logic              nv_wr_req,
  output logic [CODE_W-1:0] nv_wr_data,
  output logic [CODE_W-1:0] dac_code,
  output logic              code_valid,
  output logic              busy
);
  logic load_stb;
  logic write_done;
  logic allow;
  logic inc;
  logic dec;

  assign allow = en && !busy && !prog_req;

  trim_nv_sequencer #(.CODE_W(CODE_W), .WR_BUSY_CYCLES(WR_BUSY_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .prog_req(prog_req), .cur_code(dac_code),
    .nv_rd_req(nv_rd_req), .nv_wr_req(nv_wr_req), .nv_wr_data(nv_wr_data),
    .load_stb(load_stb), .write_done(write_done), .busy(busy)
  );

  trim_step_gate u_gate (
    .clk(clk), .rst_n(rst_n), .allow(allow), .up(step_up), .dn(step_dn),
    .write_done(write_done), .inc(inc), .dec(dec)
  );

  trim_sat_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_val(nv_rd_data),
    .inc(inc), .dec(dec), .code(dac_code), .valid(code_valid)
  );

  assert_disabled_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load_stb) |=> $stable(dac_code));
  assert_no_write_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !busy) |=> !nv_wr_req);
endmodule

// File: tb/test_trim_register.sv
module test_trim_register;
  localparam int CLK_PERIOD = 10;
  localparam int NBUSY      = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1, step_up = 1'b0, step_dn = 1'b0, prog_req = 1'b0;
  logic       nv_rd_req, nv_wr_req, code_valid, busy;
  logic [6:0] nv_rd_data, nv_wr_data, dac_code;
  logic [6:0] nv_mem = 7'd100;
  int         wr_count = 0;
  int         n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (nv_wr_req) begin
    nv_mem   <= nv_wr_data;
    wr_count <= wr_count + 1;
  end
  assign nv_rd_data = nv_mem;

  trim_register #(.CODE_W(7), .WR_BUSY_CYCLES(NBUSY)) i_trim_register (
    .clk(clk), .rst_n(rst_n), .en(en), .step_up(step_up), .step_dn(step_dn),
    .prog_req(prog_req), .nv_rd_req(nv_rd_req), .nv_rd_data(nv_rd_data),
    .nv_wr_req(nv_wr_req), .nv_wr_data(nv_wr_data), .dac_code(dac_code),
    .code_valid(code_valid), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic u, input logic d, input logic p);
    @(negedge clk); step_up = u; step_dn = d; prog_req = p;
    @(negedge clk); step_up = 0; step_dn = 0; prog_req = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 code in reset", dac_code, 0);
    check("R10 valid in reset", code_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 valid before load", code_valid, 0);
    check("R10 code before load", dac_code, 0);
    @(negedge clk);
    check("R3 valid after load", code_valid, 1);
    check("R3 code after load", dac_code, 100);
    check("R3 busy after load", busy, 0);
  endtask

  task automatic t_first_skip_and_steps();
    pulse(1, 1, 0);
    check("R11 both strobes ignored", dac_code, 100);
    pulse(1, 0, 0);
    check("R8 first strobe after power-up discarded", dac_code, 100);
    pulse(1, 0, 0);
    check("R1 up step", dac_code, 101);
    pulse(0, 1, 0);
    pulse(0, 1, 0);
    check("R1 down steps", dac_code, 99);
    pulse(1, 1, 0);
    check("R11 both strobes no change", dac_code, 99);
  endtask

  task automatic t_saturation();
    for (int i = 0; i < 40; i++) pulse(1, 0, 0);
    check("R2 saturate at max", dac_code, 127);
    for (int i = 0; i < 140; i++) pulse(0, 1, 0);
    check("R2 saturate at min", dac_code, 0);
  endtask

  task automatic t_program();
    int n;
    int wc0;
    for (int i = 0; i < 42; i++) pulse(1, 0, 0);
    check("R1 climb to 42", dac_code, 42);
    wc0 = wr_count;
    @(negedge clk); prog_req = 1;
    @(negedge clk); prog_req = 0;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R6 busy length", n, NBUSY + 1);
    check("R6 one write strobe", wr_count - wc0, 1);
    check("R6 stored value", nv_mem, 42);
    pulse(1, 0, 0);
    check("R8 first strobe after write discarded", dac_code, 42);
    pulse(1, 0, 0);
    check("R8 second strobe after write counts", dac_code, 43);
    wc0 = wr_count;
    pulse(0, 0, 1);
    pulse(1, 0, 0);
    check("R7 strobe ignored while busy", dac_code, 43);
    pulse(0, 0, 1);
    wait_idle();
    check("R7 program ignored while busy", wr_count - wc0, 1);
    check("R9 rewrite stored", nv_mem, 43);
    pulse(0, 0, 1);
    wait_idle();
    check("R9 repeated write happens", wr_count - wc0, 2);
    pulse(1, 0, 0);
    pulse(1, 0, 0);
    check("R1 step after rewrite", dac_code, 44);
  endtask

  task automatic t_enable();
    int wc0;
    wc0 = wr_count;
    @(negedge clk); en = 0;
    repeat (6) @(negedge clk);
    check("R4 reload on enable low", dac_code, 43);
    pulse(1, 0, 0);
    pulse(0, 1, 0);
    check("R5 strobes ignored when disabled", dac_code, 43);
    pulse(0, 0, 1);
    repeat (3) @(negedge clk);
    check("R5 program ignored when disabled", wr_count - wc0, 0);
    @(negedge clk); en = 1;
    repeat (2) @(negedge clk);
    pulse(1, 0, 0);
    check("R1 step after re-enable", dac_code, 44);
  endtask

  task automatic t_prog_priority();
    int wc0;
    wc0 = wr_count;
    pulse(1, 0, 1);
    check("R11 strobe with program ignored", dac_code, 44);
    wait_idle();
    check("R11 write happened", wr_count - wc0, 1);
    check("R11 write carries old code", nv_mem, 44);
  endtask

  initial begin
    t_reset();
    t_first_skip_and_steps();
    t_saturation();
    t_program();
    t_enable();
    t_prog_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule